// File: doc/BRIEF.md
# Composite Sync and Blanking Timer

This block produces the raster timing for a black-and-white, non-interlaced television picture, driven by a continuous 16 MHz clock. A column counter steps through every clock of a scan line and a row counter steps through every line of a field. Both fields of a frame are generated identically, so the same field repeats fifty times per second. From the two counts the block derives a low-going composite sync, a blanking flag that holds the picture at black, an active-picture flag, and the row and column of the current picture element within a fixed band of 256 lines. It also emits a single-clock interrupt at the start of every field.

A framebuffer fetch unit reads the row and column indices to address its memory. The video output stage combines the sync and blanking flags with the pixel data to build the three output levels. Software uses the interrupt to measure time from the top of the field, for example to locate a light sensor on the screen. Every output is registered, so each output describes the raster position that the counters held one clock earlier.

Top module: `pal_sync_gen`

## Requirements
- R1: While rst_n is low, sync_n is 1, blank is 1, active is 0, field_irq is 0 and both indices are 0. The first clock edge after release presents raster position (column 0, row 0).
- R2: A line lasts 1024 clocks and a field lasts 312 lines. Sample k after reset release shows column (k-1) mod 1024 and row ((k-1) div 1024) mod 312.
- R3: On rows 3 to 311, sync_n is 0 exactly for columns 32 to 95 (4 µs, after a 2 µs front porch) and is 1 on every other column.
- R4: On rows 0 to 2 (vertical sync), sync_n is 0 for columns 0 to 959 and 1 for the last 64 columns, 960 to 1023.
- R5: active is 1 only for columns 192 to 1023 on rows 40 to 295. blank is the inverse of active, so the rows above and below that band are black for their whole length.
- R6: While active is 1, line_idx equals row minus 40 and col_idx equals column minus 192. Both indices are 0 while active is 0.
- R7: field_irq is 1 for exactly one clock per field, at the position column 0, row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | output | 1 | Composite sync, low at the sync level |
| blank | output | 1 | High where the output must sit at black |
| active | output | 1 | High inside the active picture window |
| line_idx | output | 8 | Picture row within the active band |
| col_idx | output | 10 | Picture column within the active window |
| field_irq | output | 1 | One-clock pulse at the start of each field |

## Verification
Every output is due exactly one clock after the counters reach a position. The bench samples 2 ns after each rising edge and treats sample k, counted from reset release, as position k-1. The raster coordinates are derived by division and remainder, not by tracking the design. The bench runs a reduced configuration that has the same structure: 32-clock lines, 20-line fields and an 8-line active band. It sweeps two whole fields at every clock, so each porch edge, each band edge and the field wrap is compared at the cycle it is due. Reset is then applied again in the middle of a field to confirm the idle values and the restart at position zero.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;
  typedef struct packed {
    logic sync_n;
    logic blank;
    logic active;
    logic irq;
  } vid_ctl_t;

  localparam vid_ctl_t VID_IDLE = '{sync_n: 1'b1, blank: 1'b1, active: 1'b0, irq: 1'b0};
endpackage

// File: rtl/pal_h_timer.sv
module pal_h_timer #(
  parameter int LINE_CYCLES = 1024,
  localparam int HW = $clog2(LINE_CYCLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic          line_end
);
  logic [HW-1:0] h_nxt;

  always_comb begin
    line_end = (h_cnt == HW'(LINE_CYCLES - 1));
    h_nxt    = line_end ? '0 : h_cnt + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_cnt <= '0;
    else        h_cnt <= h_nxt;
  end
endmodule

// File: rtl/pal_v_timer.sv
module pal_v_timer #(
  parameter int FIELD_LINES = 312,
  localparam int VW = $clog2(FIELD_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [VW-1:0] v_cnt
);
  logic [VW-1:0] v_nxt;

  always_comb begin
    v_nxt = (v_cnt == VW'(FIELD_LINES - 1)) ? '0 : v_cnt + VW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   v_cnt <= '0;
    else if (adv) v_cnt <= v_nxt;
  end
endmodule

// File: rtl/pal_sync_decode.sv
module pal_sync_decode
  import pal_sync_pkg::*;
#(
  parameter int HW = 10,
  parameter int VW = 9,
  parameter int LW = 8,
  parameter int CW = 10,
  parameter int LINE_CYCLES = 1024,
  parameter int FRONT_PORCH = 32,
  parameter int HSYNC_LEN = 64,
  parameter int ACT_START = 192,
  parameter int VSYNC_LINES = 3,
  parameter int VSYNC_GAP = 64,
  parameter int ACT_FIRST = 40,
  parameter int ACT_LINES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  output vid_ctl_t      ctl_q,
  output logic [LW-1:0] line_q,
  output logic [CW-1:0] col_q
);
  vid_ctl_t      ctl_d;
  logic [LW-1:0] line_d;
  logic [CW-1:0] col_d;
  logic          vs_row, act_row, act_col, hs_col, gap_col;

  always_comb begin
    vs_row  = (v_cnt < VW'(VSYNC_LINES));
    act_row = (v_cnt >= VW'(ACT_FIRST)) && (v_cnt < VW'(ACT_FIRST + ACT_LINES));
    act_col = (h_cnt >= HW'(ACT_START));
    hs_col  = (h_cnt >= HW'(FRONT_PORCH)) && (h_cnt < HW'(FRONT_PORCH + HSYNC_LEN));
    gap_col = (h_cnt >= HW'(LINE_CYCLES - VSYNC_GAP));

    ctl_d.sync_n = vs_row ? gap_col : !hs_col;
    ctl_d.active = act_row && act_col;
    ctl_d.blank  = !(act_row && act_col);
    ctl_d.irq    = (h_cnt == '0) && (v_cnt == '0);
    line_d = ctl_d.active ? LW'(v_cnt - VW'(ACT_FIRST)) : '0;
    col_d  = ctl_d.active ? CW'(h_cnt - HW'(ACT_START)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= VID_IDLE;
      line_q <= '0;
      col_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      line_q <= line_d;
      col_q  <= col_d;
    end
  end
endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
  import pal_sync_pkg::*;
#(
  parameter int LINE_CYCLES = 1024,
  parameter int FRONT_PORCH = 32,
  parameter int HSYNC_LEN = 64,
  parameter int BACK_PORCH = 96,
  parameter int FIELD_LINES = 312,
  parameter int VSYNC_LINES = 3,
  parameter int VSYNC_GAP = 64,
  parameter int ACT_FIRST = 40,
  parameter int ACT_LINES = 256,
  localparam int HW = $clog2(LINE_CYCLES),
  localparam int VW = $clog2(FIELD_LINES),
  localparam int ACT_START = FRONT_PORCH + HSYNC_LEN + BACK_PORCH,
  localparam int LW = $clog2(ACT_LINES),
  localparam int CW = $clog2(LINE_CYCLES - ACT_START)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          sync_n,
  output logic          blank,
  output logic          active,
  output logic [LW-1:0] line_idx,
  output logic [CW-1:0] col_idx,
  output logic          field_irq
);
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          line_end;
  vid_ctl_t      ctl;

  pal_h_timer #(.LINE_CYCLES(LINE_CYCLES)) u_h (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .line_end(line_end)
  );

  pal_v_timer #(.FIELD_LINES(FIELD_LINES)) u_v (
    .clk(clk), .rst_n(rst_n), .adv(line_end), .v_cnt(v_cnt)
  );

  pal_sync_decode #(
    .HW(HW), .VW(VW), .LW(LW), .CW(CW),
    .LINE_CYCLES(LINE_CYCLES), .FRONT_PORCH(FRONT_PORCH), .HSYNC_LEN(HSYNC_LEN),
    .ACT_START(ACT_START), .VSYNC_LINES(VSYNC_LINES), .VSYNC_GAP(VSYNC_GAP),
    .ACT_FIRST(ACT_FIRST), .ACT_LINES(ACT_LINES)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt),
    .ctl_q(ctl), .line_q(line_idx), .col_q(col_idx)
  );

  assign sync_n    = ctl.sync_n;
  assign blank     = ctl.blank;
  assign active    = ctl.active;
  assign field_irq = ctl.irq;
endmodule

// File: rtl/pal_sync_chk.sv
module pal_sync_chk #(
  parameter int LW = 8,
  parameter int CW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_n,
  input logic          blank,
  input logic          active,
  input logic [LW-1:0] line_idx,
  input logic [CW-1:0] col_idx,
  input logic          field_irq
);
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_irq |=> !field_irq);

  // R4
  irq_in_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    field_irq |-> (!sync_n && blank));

  // R5
  active_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (sync_n && !blank));

  // R6
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> (col_idx == CW'($past(col_idx) + 1'b1)));

  // R6
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(line_idx));

  // R6
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (line_idx == '0 && col_idx == '0));
endmodule

bind pal_sync_gen pal_sync_chk #(.LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .blank(blank), .active(active),
  .line_idx(line_idx), .col_idx(col_idx), .field_irq(field_irq)
);

// File: tb/sim_pal_sync_gen.sv
`timescale 1ns/1ps
module sim_pal_sync_gen;
  localparam int L   = 32;
  localparam int FP  = 2;
  localparam int HS  = 4;
  localparam int BP  = 6;
  localparam int F   = 20;
  localparam int VSL = 3;
  localparam int GAP = 4;
  localparam int AF  = 4;
  localparam int AL  = 8;
  localparam int AS  = FP + HS + BP;
  localparam int LW  = $clog2(AL);
  localparam int CW  = $clog2(L - AS);

  logic          clk;
  logic          rst_n;
  logic          sync_n, blank, active, field_irq;
  logic [LW-1:0] line_idx;
  logic [CW-1:0] col_idx;
  int checks = 0;
  int fails  = 0;

  pal_sync_gen #(
    .LINE_CYCLES(L), .FRONT_PORCH(FP), .HSYNC_LEN(HS), .BACK_PORCH(BP),
    .FIELD_LINES(F), .VSYNC_LINES(VSL), .VSYNC_GAP(GAP),
    .ACT_FIRST(AF), .ACT_LINES(AL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .blank(blank), .active(active),
    .line_idx(line_idx), .col_idx(col_idx), .field_irq(field_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "sync_n idle", int'(sync_n), 1);
    chk(req, "blank idle", int'(blank), 1);
    chk(req, "active idle", int'(active), 0);
    chk(req, "irq idle", int'(field_irq), 0);
    chk(req, "line_idx idle", int'(line_idx), 0);
    chk(req, "col_idx idle", int'(col_idx), 0);
  endtask

  task automatic chk_pos(input int p);
    int h, v, e_sync, e_act;
    h = p % L;
    v = (p / L) % F;
    if (v < VSL) e_sync = (h >= L - GAP) ? 1 : 0;   // R4
    else         e_sync = (h >= FP && h < FP + HS) ? 0 : 1;  // R3
    e_act = (v >= AF && v < AF + AL && h >= AS) ? 1 : 0;
    if (v < VSL) chk("R4", "vsync sync_n", int'(sync_n), e_sync);
    else         chk("R3", "hsync sync_n", int'(sync_n), e_sync);
    chk("R5", "active", int'(active), e_act);
    chk("R5", "blank", int'(blank), 1 - e_act);
    chk("R6", "line_idx", int'(line_idx), e_act ? v - AF : 0);
    chk("R6", "col_idx", int'(col_idx), e_act ? h - AS : 0);
    chk("R7", "field_irq", int'(field_irq), (h == 0 && v == 0) ? 1 : 0);
  endtask

  initial begin
    int irq_seen, first_irq, second_irq;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk_idle("R1");
    @(negedge clk) rst_n = 1'b1;
    irq_seen = 0; first_irq = -1; second_irq = -1;
    for (int k = 1; k <= 2 * L * F + 5; k++) begin
      @(posedge clk); #2;
      chk_pos(k - 1);
      if (field_irq) begin
        irq_seen++;
        if (first_irq < 0) first_irq = k;
        else if (second_irq < 0) second_irq = k;
      end
    end
    chk("R1", "first irq sample", first_irq, 1);
    chk("R2", "field period", second_irq - first_irq, L * F);
    chk("R7", "irq count over 2 fields", irq_seen, 3);
    // reset in the middle of a field
    repeat (L * 7 + 9) @(posedge clk);
    @(negedge clk) rst_n = 1'b0;
    #2;
    chk_idle("R1");
    @(posedge clk); #2;
    chk_idle("R1");
    @(negedge clk) rst_n = 1'b1;
    for (int k = 1; k <= L * 2; k++) begin
      @(posedge clk); #2;
      if (k == 1) chk("R1", "restart irq", int'(field_irq), 1);
      chk_pos(k - 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule